// File: doc/BRIEF.md
# SSI absolute encoder receiver

This block reads position words from an absolute encoder over a synchronous serial link. When idle it holds the serial clock output high. On a start request it sends a burst of clock pulses and shifts in one data bit on each rising clock edge, most significant bit first. After the last bit it converts the word to a parallel position and pulses a one-cycle valid strobe. The position feeds a counter or comparison stage downstream.

The frame length, the bit rate and the coding are latched when a start is accepted. The frame length runs from 1 to 32 bits. The bit rate is one of eight fixed speeds, derived from an 80 MHz system clock. The coding is plain binary or Gray code, and Gray words are turned into binary before output. After each frame the clock line stays high for a recovery time of at least 20 µs, so the encoder can release its latched value. Starts that arrive during a frame or during recovery are dropped.

Top module: `ssi_pos_rx`

## Requirements
- R1: After reset, `ssi_clk_o` is 1, `pos_valid_o` is 0 and `pos_o` is 0.
- R2: A `start_i` pulse seen while idle starts a frame. The frame opens with a falling edge of `ssi_clk_o` and holds exactly N falling and N rising edges for an N-bit frame. The clock then stays high.
- R3: Each low phase and each high phase of `ssi_clk_o` lasts floor(40000 / f) system cycles, where f is the rate in kHz. `rate_sel_i` 0 to 7 selects 100, 200, 300, 400, 500, 1000, 1500 or 2000 kHz, which gives 400, 200, 133, 100, 80, 40, 26 or 20 cycles.
- R4: With `gray_en_i` = 0, the N bits are sampled on the N rising edges, with the first bit received as the most significant. They are presented right-aligned in `pos_o`, with bits N to 31 set to zero.
- R5: With `gray_en_i` = 1, the right-aligned received word g is converted so that `pos_o` bit i equals the XOR of g bits i through 31.
- R6: `frame_len_i` sets N directly for values 1 to 32. A value of 0 is treated as 1, and any value above 32 is treated as 32.
- R7: `pos_valid_o` is high for exactly one cycle per frame. `pos_o` changes only in that cycle and holds its value until the next frame completes.
- R8: Between the last rising edge of a frame and the first falling edge of the next frame, `ssi_clk_o` stays high for at least 1600 system cycles (20 µs). A start held high through recovery is taken up no more than 10 cycles after that minimum.
- R9: During a frame, changes to `start_i`, `frame_len_i`, `rate_sel_i` and `gray_en_i` have no effect on that frame's edge count, timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (80 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Read request, acted on only when idle |
| rate_sel_i | input | 3 | Bit-rate select, 0 to 7 |
| frame_len_i | input | 6 | Frame length in bits |
| gray_en_i | input | 1 | 1 = convert received Gray code to binary |
| ssi_clk_o | output | 1 | Serial clock to the encoder, idles high |
| ssi_data_i | input | 1 | Serial data from the encoder |
| pos_o | output | 32 | Right-aligned, zero-extended position |
| pos_valid_o | output | 1 | One-cycle strobe when pos_o is updated |

## Verification
The bench runs frames at every rate and checks the length of each clock phase. A wrong divider entry or an off-by-one counter shows up as a phase one cycle too long or too short. It covers one-bit, full 32-bit and out-of-range lengths. A design with a bit-count error would add or drop a clock edge, and one that does not clamp the length would hang or emit a zero-length frame. Gray words with long runs of set bits expose a conversion that stops short of the top bits or reverses the bit order. A start held through recovery, plus a start pulse and configuration changes in the middle of a frame, catch a design that begins a new frame too early or picks up settings while it is busy.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_CONV,
    ST_RECOV
  } ssi_state_e;

  // Serial rate in kHz for each select code.
  function automatic int unsigned rate_khz(input int unsigned idx);
    case (idx)
      0:       return 100;
      1:       return 200;
      2:       return 300;
      3:       return 400;
      4:       return 500;
      5:       return 1000;
      6:       return 1500;
      default: return 2000;
    endcase
  endfunction

  // System cycles in one half period of the serial clock.
  function automatic int unsigned half_cycles(input int unsigned sys_hz,
                                              input int unsigned idx);
    return sys_hz / (2000 * rate_khz(idx));
  endfunction

endpackage

// File: rtl/ssi_rate_table.sv
module ssi_rate_table
  import ssi_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 80_000_000,
  parameter int          SEL_W      = 3,
  parameter int          HALF_W     = 9
) (
  input  logic [SEL_W-1:0]  sel_i,
  output logic [HALF_W-1:0] half_o
);

  localparam int NUM_RATES = 1 << SEL_W;

  logic [HALF_W-1:0] tbl [NUM_RATES];

  for (genvar i = 0; i < NUM_RATES; i++) begin : g_entry
    assign tbl[i] = HALF_W'(half_cycles(SYS_CLK_HZ, i));
  end

  assign half_o = tbl[sel_i];

endmodule

// File: rtl/ssi_gray_dec.sv
module ssi_gray_dec #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] gray_i,
  output logic [DW-1:0] bin_o
);

  assign bin_o[DW-1] = gray_i[DW-1];

  for (genvar i = DW - 2; i >= 0; i--) begin : g_bit
    assign bin_o[i] = bin_o[i+1] ^ gray_i[i];
  end

endmodule

// File: rtl/ssi_frame_ctrl.sv
module ssi_frame_ctrl
  import ssi_pkg::*;
#(
  parameter int DW         = 32,
  parameter int LEN_W      = 6,
  parameter int HALF_W     = 9,
  parameter int CNT_W      = 11,
  parameter int REC_CYCLES = 1600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic              gray_en_i,
  input  logic              sdata_i,
  output logic              sclk_o,
  output logic [DW-1:0]     shreg_o,
  output logic              gray_o,
  output logic              done_o
);

  ssi_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [LEN_W-1:0]  bits_q;
  logic [LEN_W-1:0]  len_q;
  logic [HALF_W-1:0] half_q;
  logic [LEN_W-1:0]  len_eff;
  logic              half_end;
  logic              rec_end;

  // Length clamp: 0 becomes 1, anything above DW becomes DW.
  always_comb begin
    if (len_i == '0)
      len_eff = LEN_W'(1);
    else if (len_i > LEN_W'(DW))
      len_eff = LEN_W'(DW);
    else
      len_eff = len_i;
  end

  assign half_end = (cnt == (CNT_W'(half_q) - CNT_W'(1)));
  assign rec_end  = (cnt == CNT_W'(REC_CYCLES - 1));
  assign done_o   = (state == ST_CONV);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sclk_o  <= 1'b1;
      cnt     <= '0;
      bits_q  <= '0;
      len_q   <= LEN_W'(1);
      half_q  <= HALF_W'(1);
      gray_o  <= 1'b0;
      shreg_o <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state   <= ST_LOW;
            sclk_o  <= 1'b0;
            cnt     <= '0;
            bits_q  <= '0;
            shreg_o <= '0;
            len_q   <= len_eff;
            half_q  <= half_i;
            gray_o  <= gray_en_i;
          end
        end
        ST_LOW: begin
          if (half_end) begin
            sclk_o  <= 1'b1;
            cnt     <= '0;
            shreg_o <= {shreg_o[DW-2:0], sdata_i};
            bits_q  <= bits_q + LEN_W'(1);
            state   <= ST_HIGH;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_HIGH: begin
          if (bits_q == len_q) begin
            state <= ST_CONV;
            cnt   <= '0;
          end else if (half_end) begin
            sclk_o <= 1'b0;
            cnt    <= '0;
            state  <= ST_LOW;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_CONV: begin
          state <= ST_RECOV;
          cnt   <= '0;
        end
        ST_RECOV: begin
          if (rec_end) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          state  <= ST_IDLE;
          sclk_o <= 1'b1;
        end
      endcase
    end
  end

  AST_FALL_FROM_IDLE_OR_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |-> ($past(state) == ST_IDLE || $past(state) == ST_HIGH)); // R8

  AST_RECOV_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECOV || state == ST_CONV) |-> sclk_o); // R8

  AST_BITS_WITHIN_LEN: assert property (@(posedge clk) disable iff (rst)
    bits_q <= len_q); // R6

  AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (len_q >= LEN_W'(1)) && (len_q <= LEN_W'(DW))); // R6

  AST_PHASE_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOW || state == ST_HIGH) |-> (cnt < CNT_W'(half_q))); // R3

  AST_CFG_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> ($stable(len_q) && $stable(half_q) && $stable(gray_o))); // R9

endmodule

// File: rtl/ssi_pos_rx.sv
module ssi_pos_rx
  import ssi_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ  = 80_000_000,
  parameter int          DW          = 32,
  parameter int          RATE_SEL_W  = 3,
  parameter int          RECOVERY_US = 20,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [RATE_SEL_W-1:0]     rate_sel_i,
  input  logic [$clog2(DW+1)-1:0]   frame_len_i,
  input  logic                      gray_en_i,
  output logic                      ssi_clk_o,
  input  logic                      ssi_data_i,
  output logic [DW-1:0]             pos_o,
  output logic                      pos_valid_o
);

  localparam int LEN_W      = $clog2(DW + 1);
  localparam int HALF_MAX   = int'(SYS_CLK_HZ / (2 * 100_000));
  localparam int HALF_W     = $clog2(HALF_MAX + 1);
  localparam int REC_CYCLES = int'(SYS_CLK_HZ / 1_000_000) * RECOVERY_US;
  localparam int CNT_MAX    = (REC_CYCLES > HALF_MAX) ? REC_CYCLES : HALF_MAX;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sdata_s;
  logic [HALF_W-1:0]      half_sel;
  logic [DW-1:0]          shreg;
  logic [DW-1:0]          bin_word;
  logic                   gray_q;
  logic                   done;

  // Input synchronizer for the serial data line.
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], ssi_data_i};
  end
  assign sdata_s = sync_q[SYNC_STAGES-1];

  ssi_rate_table #(
    .SYS_CLK_HZ (SYS_CLK_HZ),
    .SEL_W      (RATE_SEL_W),
    .HALF_W     (HALF_W)
  ) u_rate (
    .sel_i  (rate_sel_i),
    .half_o (half_sel)
  );

  ssi_frame_ctrl #(
    .DW         (DW),
    .LEN_W      (LEN_W),
    .HALF_W     (HALF_W),
    .CNT_W      (CNT_W),
    .REC_CYCLES (REC_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .len_i     (frame_len_i),
    .half_i    (half_sel),
    .gray_en_i (gray_en_i),
    .sdata_i   (sdata_s),
    .sclk_o    (ssi_clk_o),
    .shreg_o   (shreg),
    .gray_o    (gray_q),
    .done_o    (done)
  );

  ssi_gray_dec #(.DW(DW)) u_gray (
    .gray_i (shreg),
    .bin_o  (bin_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_o       <= '0;
      pos_valid_o <= 1'b0;
    end else begin
      pos_valid_o <= done;
      if (done) pos_o <= gray_q ? bin_word : shreg;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pos_valid_o |=> !pos_valid_o); // R7

  AST_POS_HELD: assert property (@(posedge clk) disable iff (rst)
    !pos_valid_o |-> $stable(pos_o)); // R7

  AST_VALID_CLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    pos_valid_o |-> ssi_clk_o); // R2

  AST_GRAY_ROUNDTRIP: assert property (@(posedge clk) disable iff (rst)
    (pos_valid_o && gray_q) |-> ((pos_o ^ (pos_o >> 1)) == shreg)); // R5

  AST_BINARY_PASS: assert property (@(posedge clk) disable iff (rst)
    (pos_valid_o && !gray_q) |-> (pos_o == shreg)); // R4

endmodule

// File: tb/tb_ssi_pos_rx.sv
`timescale 1ns/100ps
module tb_ssi_pos_rx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [2:0]  rate_sel_i = 3'd7;
  logic [5:0]  frame_len_i = 6'd8;
  logic        gray_en_i = 1'b0;
  logic        ssi_clk_o;
  logic        ssi_data_i = 1'b1;
  logic [31:0] pos_o;
  logic        pos_valid_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  ssi_pos_rx dut (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .rate_sel_i  (rate_sel_i),
    .frame_len_i (frame_len_i),
    .gray_en_i   (gray_en_i),
    .ssi_clk_o   (ssi_clk_o),
    .ssi_data_i  (ssi_data_i),
    .pos_o       (pos_o),
    .pos_valid_o (pos_valid_o)
  );

  // Encoder model: next bit, MSB first, after each falling clock edge.
  logic [31:0] enc_word = '0;
  int          enc_len  = 0;
  int          enc_seq  = 0;
  int          enc_seen = 0;
  int          enc_idx  = 0;

  always @(negedge ssi_clk_o) begin
    if (enc_seen != enc_seq) begin
      enc_seen = enc_seq;
      enc_idx  = 0;
    end
    if (enc_idx < enc_len) ssi_data_i <= #1 enc_word[enc_len-1-enc_idx];
    else                   ssi_data_i <= #1 1'b0;
    enc_idx = enc_idx + 1;
  end

  // Passive edge monitor.
  logic prev_sclk = 1'b1;
  int n_fall = 0, n_rise = 0, n_valid = 0;
  int low_run = 0, high_run = 0, last_low = 0, last_gap = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_sclk && !ssi_clk_o) begin
        n_fall++; last_gap = high_run; low_run = 1;
      end else if (!prev_sclk && ssi_clk_o) begin
        n_rise++; last_low = low_run; high_run = 1;
      end else if (ssi_clk_o) high_run++;
      else low_run++;
      if (pos_valid_o) n_valid++;
    end
    prev_sclk = ssi_clk_o;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int half_exp(input int r);
    case (r)
      0: return 400; 1: return 200; 2: return 133; 3: return 100;
      4: return 80;  5: return 40;  6: return 26;  default: return 20;
    endcase
  endfunction

  function automatic logic [31:0] exp_pos(input logic [31:0] w, input int el,
                                          input bit g);
    logic [31:0] v, b;
    v = (el >= 32) ? w : (w & ((32'd1 << el) - 32'd1));
    if (!g) return v;
    b[31] = v[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ v[i];
    return b;
  endfunction

  task automatic wait_valid(output logic [31:0] got, output bit ok);
    ok = 0;
    got = '0;
    for (int t = 0; t < 60000; t++) begin
      tick();
      if (pos_valid_o) begin got = pos_o; ok = 1; break; end
    end
  endtask

  // One frame from idle; el is the effective length the encoder sends.
  task automatic run_frame(input logic [31:0] w, input logic [5:0] len_in,
                           input bit g, input int r, input int el,
                           input bit disturb, input string req);
    int f0, r0, v0;
    logic [31:0] got, exp;
    bit ok;
    enc_word = w; enc_len = el; enc_seq++;
    rate_sel_i = 3'(r); frame_len_i = len_in; gray_en_i = g;
    f0 = n_fall; r0 = n_rise; v0 = n_valid;
    start_i = 1'b1; tick(); start_i = 1'b0;
    if (disturb) begin
      repeat (3 * half_exp(r)) tick();
      start_i = 1'b1; frame_len_i = 6'd2; gray_en_i = ~g; rate_sel_i = 3'(r ^ 1);
      tick(); start_i = 1'b0;
    end
    wait_valid(got, ok);
    exp = exp_pos(w, el, g);
    chk(req, 32'(ok), 32'd1, "valid seen");
    chk(req, got, exp, "position");
    chk("R2", 32'(n_fall - f0), 32'(el), "falling edges");
    chk("R2", 32'(n_rise - r0), 32'(el), "rising edges");
    chk("R3", 32'(last_low), 32'(half_exp(r)), "low phase cycles");
    repeat (1620) tick();
    chk("R7", 32'(n_valid - v0), 32'd1, "valid pulses per frame");
    chk("R7", pos_o, exp, "position held");
    chk("R2", 32'(ssi_clk_o), 32'd1, "clock idles high");
  endtask

  localparam int NV = 10;
  localparam logic [31:0] V_WORD [NV] = '{32'hA5, 32'h3C, 32'hDEADBEEF,
    32'hDEADBEEF, 32'h1, 32'h1FFF, 32'h2AB, 32'h5, 32'hB, 32'hB};
  localparam int V_LEN  [NV] = '{8, 8, 32, 32, 1, 13, 10, 3, 4, 4};
  localparam bit V_GRAY [NV] = '{0, 1, 0, 1, 0, 1, 0, 1, 0, 1};
  localparam int V_RATE [NV] = '{7, 7, 6, 5, 7, 4, 3, 2, 1, 0};

  initial begin
    logic [31:0] got;
    bit ok;
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1", 32'(ssi_clk_o), 32'd1, "clock after reset");
    chk("R1", 32'(pos_valid_o), 32'd0, "valid after reset");
    chk("R1", pos_o, 32'd0, "position after reset");

    // Vector table: R4 binary, R5 Gray, R3 all rates.
    for (int k = 0; k < NV; k++)
      run_frame(V_WORD[k], 6'(V_LEN[k]), V_GRAY[k], V_RATE[k], V_LEN[k], 1'b0,
                V_GRAY[k] ? "R5" : "R4");

    // R6 length clamps.
    run_frame(32'h1, 6'd0, 1'b0, 7, 1, 1'b0, "R6");
    run_frame(32'hF00DCAFE, 6'd40, 1'b0, 7, 32, 1'b0, "R6");
    run_frame(32'h80000001, 6'd63, 1'b1, 6, 32, 1'b0, "R6");

    // R9 mid-frame start and configuration changes.
    run_frame(32'h0000C3A5, 6'd16, 1'b0, 6, 16, 1'b1, "R9");
    run_frame(32'h00F0F0F0, 6'd24, 1'b1, 7, 24, 1'b1, "R9");

    // R8 start held through recovery.
    enc_word = 32'h5A; enc_len = 8; enc_seq++;
    rate_sel_i = 3'd7; frame_len_i = 6'd8; gray_en_i = 1'b0;
    start_i = 1'b1; tick(); start_i = 1'b0;
    wait_valid(got, ok);
    chk("R8", got, 32'h5A, "first frame of pair");
    begin
      int f0;
      f0 = n_fall;
      enc_word = 32'h96; enc_seq++;
      start_i = 1'b1;
      for (int t = 0; t < 3000 && n_fall == f0; t++) tick();
      start_i = 1'b0;
      checks++;
      if (last_gap < 1600 || last_gap > 1610) begin
        errors++;
        $display("FAIL R8 recovery gap: actual=%0d expected=1600..1610", last_gap);
      end
    end
    wait_valid(got, ok);
    chk("R8", got, 32'h96, "frame after recovery");
    repeat (1620) tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule